// File: doc/BRIEF.md
# I2C Target Receiver with Held-Byte Buffer

This block is the bus-facing side of an I2C target (slave) device. It takes the SCL and SDA bus wires as plain inputs, passes each one through a synchronizer and decodes START and STOP conditions. It shifts in address and data bytes and compares the address with a programmable 7-bit or 10-bit own address. Every byte it accepts goes into a single holding register, and the host reads that register. The block acknowledges by pulling SDA low. When the controller addresses it for a read, it places transmit bytes on SDA, and because the line is open-drain it only ever drives SDA low.

The acknowledge depends on the state of the buffer. If an earlier byte has not been read yet, or if an overflow is still pending, the block answers the next byte with a NACK and discards that byte. The interrupt flag is still raised. The host clears buffer-full by reading the holding register. It clears the overflow flag and the interrupt flag by explicit strobes. A 4-bit mode field selects the address width and whether START and STOP also raise the interrupt.

The protocol state machine has these states:

- **S_IDLE**: reached from reset, on a STOP, or while the block is inactive.
- **S_ADDR1**: entered on any START. It receives the first address byte.
- **S_ADDR2**: receives the low address byte in 10-bit mode.
- **S_RX**: receives data bytes.
- **S_ACK**: the ninth clock. SDA is held low there for an ACK, or released for a NACK. On the falling SCL edge that ends the ninth clock, the machine moves to a stored return state: S_ADDR2, S_RX, S_TX or S_SKIP.
- **S_TX**: shifts out a transmit byte.
- **S_TX_ACK**: samples the controller's acknowledge. An ACK leads back to S_TX with a fresh byte. A NACK leads to S_SKIP.
- **S_SKIP**: ignores the bus until the next START or STOP.

Top module: `i2c_target_rx`

## Requirements
- R1: While `en` is low, `sda_oe` stays low and bus traffic sets none of `buf_full`, `ovf` or `irq`.
- R2: `mode` selects the operation. 4'b0110 is 7-bit addressing. 4'b0111 is 10-bit addressing. 4'b1110 is 7-bit addressing with START/STOP interrupts. 4'b1111 is 10-bit addressing with START/STOP interrupts. Any other code leaves the target idle: it gives no ACK and changes no flag.
- R3: In 7-bit modes, a first byte whose bits [7:1] equal `own_addr[6:0]` is a match. Bit 0 is the R/W bit, with 1 meaning read. On a match with the buffer free, the block ACKs by holding SDA low during the ninth clock, copies the address byte into `rx_data`, and sets `buf_full` and `irq`. A mismatched address gets no ACK and changes no flag.
- R4: In 10-bit modes, a first byte of 11110, `own_addr[9:8]`, 0 is ACKed without setting any flag. A following byte equal to `own_addr[7:0]` completes the match, which ACKs, loads `rx_data`, and sets `buf_full` and `irq`. A mismatched second byte gets no ACK.
- R5: After a write match, each data byte received while the buffer is free is ACKed, copied into `rx_data`, and sets `buf_full` and `irq`.
- R6: A byte that completes while `buf_full` is already set is NACKed. `rx_data` keeps its value, and `ovf` and `irq` are set.
- R7: A byte that completes while `ovf` is set, even with `buf_full` clear, is NACKed. `rx_data` keeps its value and `irq` is set.
- R8: A one-cycle `rd_strobe` clears `buf_full`. `ovf` clears only on `ovf_clr`. `irq` clears only on `irq_clr`. A new setting event wins over a clear in the same cycle.
- R9: In the START/STOP interrupt modes, every START and every STOP sets `irq`. In the other modes, START and STOP leave `irq` unchanged.
- R10: After a read match, the block sends `tx_data` MSB first. It drives SDA low only for 0 bits. It loads the next `tx_data` when the controller ACKs, and releases SDA for good after a controller NACK.
- R11: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. After a STOP, clock pulses without a new START are ignored: there is no ACK and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable |
| mode | input | 4 | Operating mode code |
| own_addr | input | 10 | Own target address (bits [6:0] used in 7-bit modes) |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| sda_oe | output | 1 | When high, pull SDA low |
| tx_data | input | 8 | Byte to transmit in read transfers |
| rd_strobe | input | 1 | Host read of the holding register |
| ovf_clr | input | 1 | Host clear of the overflow flag |
| irq_clr | input | 1 | Host clear of the interrupt flag |
| rx_data | output | 8 | Holding register |
| buf_full | output | 1 | Holding register contains an unread byte |
| ovf | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt flag |

## Verification
A wrong bit counter or a wrong return state shows up within one byte as a missing or misplaced low level on SDA during the ninth clock. The bench samples SDA in the middle of each acknowledge clock. Wrong buffer-flag state shows up on the next completed byte: the acknowledge polarity, `rx_data`, `ovf` and `irq` are all checked a few cycles after that byte's acknowledge clock ends. A wrong transmit shift register or reload shows up as corrupted bits in the very next byte the controller reads.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 10;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    localparam logic [3:0] MODE_A7     = 4'b0110;
    localparam logic [3:0] MODE_A10    = 4'b0111;
    localparam logic [3:0] MODE_A7_SS  = 4'b1110;
    localparam logic [3:0] MODE_A10_SS = 4'b1111;

    localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR1,
        S_ADDR2,
        S_RX,
        S_ACK,
        S_TX,
        S_TX_ACK,
        S_SKIP
    } tgt_state_e;

    typedef struct packed {
        logic active;
        logic ten_bit;
        logic ss_irq;
    } mode_dec_t;

    function automatic mode_dec_t decode_mode(input logic [3:0] code);
        mode_dec_t d;
        d = '0;
        unique case (code)
            MODE_A7:     d = '{active: 1'b1, ten_bit: 1'b0, ss_irq: 1'b0};
            MODE_A10:    d = '{active: 1'b1, ten_bit: 1'b1, ss_irq: 1'b0};
            MODE_A7_SS:  d = '{active: 1'b1, ten_bit: 1'b0, ss_irq: 1'b1};
            MODE_A10_SS: d = '{active: 1'b1, ten_bit: 1'b1, ss_irq: 1'b1};
            default:     d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_p  <= scl_ff[STAGES-1];
            sda_p  <= sda_ff[STAGES-1];
        end
    end

    always_comb begin
        scl_s     = scl_ff[STAGES-1];
        sda_s     = sda_ff[STAGES-1];
        scl_rise  = scl_s && !scl_p;
        scl_fall  = !scl_s && scl_p;
        start_det = scl_s && scl_p && sda_p && !sda_s;
        stop_det  = scl_s && scl_p && !sda_p && sda_s;
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              ten_bit,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              ack_ok,
    input  logic [DATA_W-1:0] tx_data,
    output logic              sda_oe,
    output logic              byte_evt,
    output logic [DATA_W-1:0] byte_val
);

    localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    tgt_state_e        state_q, state_d;
    tgt_state_e        ret_q, ret_d;
    logic              ack_q, ack_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [DATA_W-1:0] sr_q, sr_d;
    logic [DATA_W-1:0] tx_q, tx_d;
    logic              a10_q, a10_d;
    logic              mack_q, mack_d;
    logic              hi_match;
    logic              lo7_match;
    logic              lo10_match;

    always_comb begin
        hi_match   = (sr_q[7:3] == TEN_BIT_TAG) && (sr_q[2:1] == own_addr[9:8]);
        lo7_match  = (sr_q[7:1] == own_addr[6:0]);
        lo10_match = (sr_q == own_addr[7:0]);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_q  <= S_SKIP;
            ack_q  <= 1'b0;
            cnt_q  <= '0;
            sr_q   <= '0;
            tx_q   <= '1;
            a10_q  <= 1'b0;
            mack_q <= 1'b0;
        end else begin
            ret_q  <= ret_d;
            ack_q  <= ack_d;
            cnt_q  <= cnt_d;
            sr_q   <= sr_d;
            tx_q   <= tx_d;
            a10_q  <= a10_d;
            mack_q <= mack_d;
        end
    end

    // next state and datapath
    always_comb begin
        state_d  = state_q;
        ret_d    = ret_q;
        ack_d    = ack_q;
        cnt_d    = cnt_q;
        sr_d     = sr_q;
        tx_d     = tx_q;
        a10_d    = a10_q;
        mack_d   = mack_q;
        byte_evt = 1'b0;
        if (!active) begin
            state_d = S_IDLE;
            ack_d   = 1'b0;
            a10_d   = 1'b0;
        end else if (start_det) begin
            state_d = S_ADDR1;
            cnt_d   = '0;
            ack_d   = 1'b0;
        end else if (stop_det) begin
            state_d = S_IDLE;
            ack_d   = 1'b0;
            a10_d   = 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE, S_SKIP: begin
                    state_d = state_q;
                end
                S_ADDR1, S_ADDR2, S_RX: begin
                    if (scl_rise) begin
                        sr_d  = {sr_q[DATA_W-2:0], sda_s};
                        cnt_d = cnt_q + CNT_ONE;
                    end else if (scl_fall && (cnt_q == BYTE_BITS)) begin
                        cnt_d   = '0;
                        state_d = S_ACK;
                        ack_d   = 1'b0;
                        ret_d   = S_SKIP;
                        if (state_q == S_ADDR1) begin
                            if (!ten_bit) begin
                                if (lo7_match) begin
                                    byte_evt = 1'b1;
                                    ack_d    = ack_ok;
                                    ret_d    = !ack_ok ? S_SKIP : (sr_q[0] ? S_TX : S_RX);
                                end
                            end else if (hi_match) begin
                                if (!sr_q[0]) begin
                                    ack_d = 1'b1;
                                    ret_d = S_ADDR2;
                                end else if (a10_q) begin
                                    byte_evt = 1'b1;
                                    ack_d    = ack_ok;
                                    ret_d    = ack_ok ? S_TX : S_SKIP;
                                end
                            end
                        end else if (state_q == S_ADDR2) begin
                            if (lo10_match) begin
                                byte_evt = 1'b1;
                                a10_d    = 1'b1;
                                ack_d    = ack_ok;
                                ret_d    = ack_ok ? S_RX : S_SKIP;
                            end
                        end else begin
                            byte_evt = 1'b1;
                            ack_d    = ack_ok;
                            ret_d    = ack_ok ? S_RX : S_SKIP;
                        end
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        state_d = ret_q;
                        ack_d   = 1'b0;
                        cnt_d   = '0;
                        if (ret_q == S_TX) tx_d = tx_data;
                    end
                end
                S_TX: begin
                    if (scl_rise) begin
                        cnt_d = cnt_q + CNT_ONE;
                    end else if (scl_fall) begin
                        if (cnt_q == BYTE_BITS) begin
                            state_d = S_TX_ACK;
                            cnt_d   = '0;
                        end else begin
                            tx_d = {tx_q[DATA_W-2:0], 1'b1};
                        end
                    end
                end
                S_TX_ACK: begin
                    if (scl_rise) begin
                        mack_d = !sda_s;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            state_d = S_TX;
                            tx_d    = tx_data;
                        end else begin
                            state_d = S_SKIP;
                        end
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        byte_val = sr_q;
        unique case (state_q)
            S_ACK:   sda_oe = ack_q;
            S_TX:    sda_oe = !tx_q[DATA_W-1];
            default: sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_tgt_flags.sv
module i2c_tgt_flags
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_evt,
    input  logic [DATA_W-1:0] byte_val,
    input  logic              ss_evt,
    input  logic              rd_strobe,
    input  logic              ovf_clr,
    input  logic              irq_clr,
    output logic              ack_ok,
    output logic              buf_load,
    output logic              irq_set,
    output logic [DATA_W-1:0] rx_data,
    output logic              buf_full,
    output logic              ovf,
    output logic              irq
);

    always_comb begin
        ack_ok   = !buf_full && !ovf;
        buf_load = byte_evt && ack_ok;
        irq_set  = byte_evt || ss_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data  <= '0;
            buf_full <= 1'b0;
            ovf      <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (buf_load)       rx_data <= byte_val;

            if (buf_load)       buf_full <= 1'b1;
            else if (rd_strobe) buf_full <= 1'b0;

            if (byte_evt && buf_full) ovf <= 1'b1;
            else if (ovf_clr)         ovf <= 1'b0;

            if (irq_set)      irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_target_rx.sv
module i2c_target_rx
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [3:0]        mode,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rd_strobe,
    input  logic              ovf_clr,
    input  logic              irq_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              buf_full,
    output logic              ovf,
    output logic              irq
);

    mode_dec_t         md;
    logic              active;
    logic              ss_evt;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              ack_ok;
    logic              byte_evt;
    logic [DATA_W-1:0] byte_val;
    logic              buf_load;
    logic              irq_set;

    always_comb begin
        md     = decode_mode(mode);
        active = en && md.active;
        ss_evt = active && md.ss_irq && (start_det || stop_det);
    end

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_engine engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .ten_bit   (md.ten_bit),
        .own_addr  (own_addr),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .ack_ok    (ack_ok),
        .tx_data   (tx_data),
        .sda_oe    (sda_oe),
        .byte_evt  (byte_evt),
        .byte_val  (byte_val)
    );

    i2c_tgt_flags flags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_evt  (byte_evt),
        .byte_val  (byte_val),
        .ss_evt    (ss_evt),
        .rd_strobe (rd_strobe),
        .ovf_clr   (ovf_clr),
        .irq_clr   (irq_clr),
        .ack_ok    (ack_ok),
        .buf_load  (buf_load),
        .irq_set   (irq_set),
        .rx_data   (rx_data),
        .buf_full  (buf_full),
        .ovf       (ovf),
        .irq       (irq)
    );

endmodule

// File: rtl/i2c_target_rx_chk.sv
module i2c_target_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       sda_oe,
    input logic       rd_strobe,
    input logic       ovf_clr,
    input logic [7:0] rx_data,
    input logic       buf_full,
    input logic       ovf,
    input logic       irq,
    input logic       buf_load,
    input logic       irq_set
);

    assert_no_drive_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> !sda_oe);

    assert_flags_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!$rose(buf_full) && !$rose(ovf)));

    assert_load_sets_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_load |=> (buf_full && irq));

    assert_no_overflow_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $stable(rx_data));

    assert_read_clears_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !buf_load) |=> !buf_full);

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_set));

endmodule

bind i2c_target_rx i2c_target_rx_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .sda_oe    (sda_oe),
    .rd_strobe (rd_strobe),
    .ovf_clr   (ovf_clr),
    .rx_data   (rx_data),
    .buf_full  (buf_full),
    .ovf       (ovf),
    .irq       (irq),
    .buf_load  (buf_load),
    .irq_set   (irq_set)
);

// File: tb/i2c_target_rx_tb_top.sv
module i2c_target_rx_tb_top;

    localparam int H = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [3:0] mode = 4'b0110;
    logic [9:0] own_addr = 10'h02A;
    logic       m_scl = 1'b1;
    logic       m_sda_low = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       rd_strobe = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       irq_clr = 1'b0;
    logic       sda_oe;
    logic [7:0] rx_data;
    logic       buf_full;
    logic       ovf;
    logic       irq;
    logic       sda_line;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = !(m_sda_low || sda_oe);

    i2c_target_rx dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .mode      (mode),
        .own_addr  (own_addr),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .tx_data   (tx_data),
        .rd_strobe (rd_strobe),
        .ovf_clr   (ovf_clr),
        .irq_clr   (irq_clr),
        .rx_data   (rx_data),
        .buf_full  (buf_full),
        .ovf       (ovf),
        .irq       (irq)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; wait_cyc(H);
        m_scl = 1'b1;     wait_cyc(H);
        m_sda_low = 1'b1; wait_cyc(H);
        m_scl = 1'b0;     wait_cyc(4);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wait_cyc(H);
        m_scl = 1'b1;     wait_cyc(H);
        m_sda_low = 1'b0; wait_cyc(H);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = !b[i]; wait_cyc(H);
            m_scl = 1'b1;      wait_cyc(H);
            m_scl = 1'b0;      wait_cyc(2);
        end
        m_sda_low = 1'b0; wait_cyc(H);
        m_scl = 1'b1;     wait_cyc(H/2);
        acked = !sda_line;
        wait_cyc(H/2);
        m_scl = 1'b0;     wait_cyc(8);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wait_cyc(H);
            m_scl = 1'b1; wait_cyc(H/2);
            b[i] = sda_line;
            wait_cyc(H/2);
            m_scl = 1'b0; wait_cyc(2);
        end
        m_sda_low = give_ack; wait_cyc(H);
        m_scl = 1'b1;         wait_cyc(H);
        m_scl = 1'b0;         wait_cyc(2);
        m_sda_low = 1'b0;     wait_cyc(8);
    endtask

    task automatic host_pulse_rd();  rd_strobe = 1'b1; wait_cyc(1); rd_strobe = 1'b0; wait_cyc(1); endtask
    task automatic host_clear_all();
        rd_strobe = 1'b1; ovf_clr = 1'b1; irq_clr = 1'b1; wait_cyc(1);
        rd_strobe = 1'b0; ovf_clr = 1'b0; irq_clr = 1'b0; wait_cyc(1);
    endtask
    task automatic host_clr_irq(); irq_clr = 1'b1; wait_cyc(1); irq_clr = 1'b0; wait_cyc(1); endtask

    task automatic t_reset();
        check("R1", "reset sda_oe", sda_oe, 0);
        check("R8", "reset buf_full", buf_full, 0);
        check("R8", "reset ovf", ovf, 0);
        check("R8", "reset irq", irq, 0);
    endtask

    task automatic t_addr7_write();
        logic a;
        mode = 4'b0110; own_addr = 10'h02A; host_clear_all();
        bus_start();
        check("R9", "no irq on start in plain mode", irq, 0);
        write_byte(8'h54, a);
        check("R3", "ack on 7-bit match", a, 1);
        check("R3", "rx holds address", rx_data, 8'h54);
        check("R3", "buf_full after match", buf_full, 1);
        check("R3", "irq after match", irq, 1);
        host_pulse_rd(); host_clr_irq();
        check("R8", "read clears buf_full", buf_full, 0);
        write_byte(8'hA5, a);
        check("R5", "ack on data", a, 1);
        check("R5", "rx data", rx_data, 8'hA5);
        check("R5", "irq on data", irq, 1);
        host_pulse_rd(); host_clr_irq();
        bus_stop();
        check("R9", "no irq on stop in plain mode", irq, 0);
    endtask

    task automatic t_mismatch();
        logic a;
        host_clear_all();
        bus_start();
        write_byte(8'h66, a);
        check("R3", "no ack on mismatch", a, 0);
        check("R3", "no buf_full on mismatch", buf_full, 0);
        check("R3", "no irq on mismatch", irq, 0);
        bus_stop();
    endtask

    task automatic t_full_nack();
        logic a;
        host_clear_all();
        bus_start();
        write_byte(8'h54, a);
        check("R3", "ack address", a, 1);
        host_clr_irq();
        write_byte(8'h11, a);
        check("R6", "nack when full", a, 0);
        check("R6", "rx unchanged", rx_data, 8'h54);
        check("R6", "ovf set", ovf, 1);
        check("R6", "irq set on nack", irq, 1);
        bus_stop();
        host_pulse_rd(); host_clr_irq();
        check("R8", "buf_full cleared by read", buf_full, 0);
        check("R8", "ovf survives read", ovf, 1);
        bus_start();
        write_byte(8'h54, a);
        check("R7", "nack when ovf pending", a, 0);
        check("R7", "rx unchanged", rx_data, 8'h54);
        check("R7", "buf_full stays clear", buf_full, 0);
        check("R7", "irq still set", irq, 1);
        bus_stop();
        ovf_clr = 1'b1; wait_cyc(1); ovf_clr = 1'b0; wait_cyc(1);
        check("R8", "ovf_clr clears ovf", ovf, 0);
    endtask

    task automatic t_ss_irq();
        mode = 4'b1110; host_clear_all();
        bus_start();
        check("R9", "irq on start", irq, 1);
        host_clr_irq();
        bus_stop();
        check("R9", "irq on stop", irq, 1);
        host_clr_irq();
        mode = 4'b0110;
    endtask

    task automatic t_addr10();
        logic a;
        mode = 4'b0111; own_addr = 10'h2D5; host_clear_all();
        bus_start();
        write_byte(8'hF4, a);
        check("R4", "ack on 10-bit high byte", a, 1);
        check("R4", "no irq after high byte", irq, 0);
        check("R4", "no buf_full after high byte", buf_full, 0);
        write_byte(8'hD5, a);
        check("R4", "ack on low byte", a, 1);
        check("R4", "rx low byte", rx_data, 8'hD5);
        check("R4", "irq after full match", irq, 1);
        host_pulse_rd(); host_clr_irq();
        write_byte(8'h3C, a);
        check("R5", "10-bit data ack", a, 1);
        check("R5", "10-bit data value", rx_data, 8'h3C);
        host_pulse_rd(); host_clr_irq();
        bus_stop();
        bus_start();
        write_byte(8'hF4, a);
        write_byte(8'hD4, a);
        check("R4", "no ack on wrong low byte", a, 0);
        check("R4", "no irq on wrong low byte", irq, 0);
        bus_stop();
        mode = 4'b0110; own_addr = 10'h02A;
    endtask

    task automatic t_tx();
        logic       a;
        logic [7:0] b;
        host_clear_all();
        tx_data = 8'hC3;
        bus_start();
        write_byte(8'h55, a);
        check("R10", "ack on read address", a, 1);
        check("R10", "rx holds read address", rx_data, 8'h55);
        host_pulse_rd(); host_clr_irq();
        tx_data = 8'h5A;
        read_byte(1'b1, b);
        check("R10", "first tx byte", b, 8'hC3);
        read_byte(1'b0, b);
        check("R10", "second tx byte", b, 8'h5A);
        wait_cyc(H);
        check("R10", "released after nack", sda_oe, 0);
        check("R10", "no flag on tx", buf_full, 0);
        bus_stop();
    endtask

    task automatic t_disabled();
        logic a;
        host_clear_all();
        en = 1'b0;
        bus_start();
        write_byte(8'h54, a);
        check("R1", "no ack while disabled", a, 0);
        check("R1", "no buf_full while disabled", buf_full, 0);
        check("R1", "no irq while disabled", irq, 0);
        bus_stop();
        en = 1'b1;
    endtask

    task automatic t_bad_mode();
        logic a;
        host_clear_all();
        mode = 4'b0000;
        bus_start();
        write_byte(8'h54, a);
        check("R2", "no ack in idle mode", a, 0);
        check("R2", "no flags in idle mode", {buf_full, ovf, irq}, 3'b000);
        bus_stop();
        mode = 4'b0110;
    endtask

    task automatic t_after_stop();
        logic a;
        host_clear_all();
        m_scl = 1'b0; wait_cyc(H);
        write_byte(8'h54, a);
        check("R11", "no ack without start", a, 0);
        check("R11", "no buf_full without start", buf_full, 0);
        m_sda_low = 1'b0; wait_cyc(H);
        m_scl = 1'b1; wait_cyc(H);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        t_reset();
        en = 1'b1;
        wait_cyc(5);
        t_addr7_write();
        t_mismatch();
        t_full_nack();
        t_ss_irq();
        t_addr10();
        t_tx();
        t_disabled();
        t_bad_mode();
        t_after_stop();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule